// File: doc/BRIEF.md
# Privilege-Gated Counter Bank

This block holds the 64-bit counters a processor hart exposes to software: a free-running cycle counter, a wall-time counter that advances on an external tick, and an instructions-retired counter that advances on a retire pulse. Indices 3 to 31 are generic performance counters. They have no event logic of their own, so each of them reports the cycle count.

A combinational read port takes a counter index and the hart's current privilege. It returns either the counter value, or zero together with a disabled flag when the current privilege may not see that counter. Two 32-bit enable masks control what lower privileges may read. One mask is consulted when the hart runs at supervisor level, and the other when it runs at user level. Machine level always sees everything. A write port updates the two masks. Writes aimed at the counters themselves are dropped. The read and write ports are plain single-cycle strobes with no valid/ready handshake: a read is answered in the same cycle, and a write is taken on the clock edge where its enable is high.

Top module: `perf_counter_bank`

## Requirements
- R1: The cycle counter (read index 0) is zero while reset is held and increases by exactly one on every rising clock edge after reset is released.
- R2: The time counter (read index 1) increases by one on each edge where the tick input is high. The instructions-retired counter (read index 2) increases by one on each edge where the retire input is high. Both are zero after reset.
- R3: A permitted read of any index from 3 to 31 returns the current cycle count.
- R4: At privilege code 3 (machine), every read of indices 0 to 31 is permitted, whatever the enable masks hold.
- R5: At privilege code 1 (supervisor), a read of index n is permitted only if bit n of the machine-level mask is set. At privilege code 0 (user), a read of index n is permitted only if bit n of the supervisor-level mask is set.
- R6: A read that is not permitted returns zero and raises the disabled flag in the same cycle as the address. A permitted read keeps the flag low.
- R7: A write to address 32 loads the machine-level mask, and a write to address 33 loads the supervisor-level mask. Writes to addresses 0 to 31 and 34 to 63 change no counter and no mask.
- R8: Both masks reset to 0x7, so lower privileges may read indices 0, 1 and 2 and no other index.
- R9: Privilege code 2 is reserved: every read of indices 0 to 31 at that code is blocked.
- R10: A read index from 32 to 63 is illegal: the data is zero, the illegal flag is high and the disabled flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| retire_i | input | 1 | One instruction retired this cycle |
| tick_i | input | 1 | Wall-time tick this cycle |
| rd_addr_i | input | 6 | Counter index to read |
| rd_data_o | output | 64 | Counter value, or zero when blocked or illegal |
| rd_disabled_o | output | 1 | Read blocked by privilege |
| rd_illegal_o | output | 1 | Read index out of range |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 6 | Write target: 32 machine mask, 33 supervisor mask, others dropped |
| wr_data_i | input | 32 | Mask value to load |

## Verification
The hardest case to reach is the full cross of privilege code, mask bit and index. This matters most where the two masks disagree, because a design that consults the wrong mask for a given privilege only misbehaves on those bits. The stimulus loads the two masks with different complementary patterns, then with all-ones against all-zeros in both orders. For each loading it sweeps all four privilege codes over all 64 read indices while retire and tick pulses keep the three base counters apart in value. A reset in the middle of the run then confirms that the masks return to their defaults after they have been rewritten.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  localparam int unsigned IDX_CYCLE   = 0;
  localparam int unsigned IDX_TIME    = 1;
  localparam int unsigned IDX_INSTRET = 2;
  localparam int unsigned NUM_BASE    = 3;
endpackage

// File: rtl/pcb_counters.sv
module pcb_counters #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cycle_o,
  output logic [CNT_W-1:0] time_o,
  output logic [CNT_W-1:0] instret_o
);
  import pcb_pkg::*;

  logic [NUM_BASE-1:0]       bump;
  logic [NUM_BASE*CNT_W-1:0] cnt_flat;

  // increment condition per base counter, indexed like the read port
  always_comb begin
    bump              = '0;
    bump[IDX_CYCLE]   = 1'b1;
    bump[IDX_TIME]    = tick_i;
    bump[IDX_INSTRET] = retire_i;
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (bump[g]) q <= q + 1'b1;
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = q;
  end

  assign cycle_o   = cnt_flat[IDX_CYCLE*CNT_W   +: CNT_W];
  assign time_o    = cnt_flat[IDX_TIME*CNT_W    +: CNT_W];
  assign instret_o = cnt_flat[IDX_INSTRET*CNT_W +: CNT_W];
endmodule

// File: rtl/pcb_enables.sv
module pcb_enables #(
  parameter int unsigned NUM_CNT   = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [31:0] RESET_VAL = 32'h7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [NUM_CNT-1:0] wr_data_i,
  output logic [NUM_CNT-1:0] mach_mask_o,
  output logic [NUM_CNT-1:0] super_mask_o
);
  localparam int unsigned NUM_MASK = 2;

  logic [NUM_MASK*NUM_CNT-1:0] mask_flat;

  // mask 0 sits at address NUM_CNT, mask 1 right after it
  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(NUM_CNT + g);
    logic [NUM_CNT-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= RESET_VAL[NUM_CNT-1:0];
      else if (wr_en_i && wr_addr_i == MY_ADDR) q <= wr_data_i;
    end
    assign mask_flat[g*NUM_CNT +: NUM_CNT] = q;
  end

  assign mach_mask_o  = mask_flat[0       +: NUM_CNT];
  assign super_mask_o = mask_flat[NUM_CNT +: NUM_CNT];
endmodule

// File: rtl/pcb_gate.sv
module pcb_gate #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic [1:0]         priv_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [NUM_CNT-1:0] mach_mask_i,
  input  logic [NUM_CNT-1:0] super_mask_i,
  input  logic [CNT_W-1:0]   cycle_i,
  input  logic [CNT_W-1:0]   time_i,
  input  logic [CNT_W-1:0]   instret_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               rd_disabled_o,
  output logic               rd_illegal_o
);
  import pcb_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_CNT);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             allow;
  logic [CNT_W-1:0] value;

  assign in_range = rd_addr_i < ADDR_W'(NUM_CNT);
  assign idx      = rd_addr_i[IDX_W-1:0];

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_MACH:  allow = 1'b1;
      PRIV_SUPER: allow = mach_mask_i[idx];
      PRIV_USER:  allow = super_mask_i[idx];
      default:    allow = 1'b0;
    endcase
  end

  always_comb begin
    if (idx == IDX_W'(IDX_TIME))         value = time_i;
    else if (idx == IDX_W'(IDX_INSTRET)) value = instret_i;
    else                                 value = cycle_i;
  end

  assign rd_illegal_o  = !in_range;
  assign rd_disabled_o = in_range && !allow;
  assign rd_data_o     = (in_range && allow) ? value : '0;
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         priv_i,
  input  logic               retire_i,
  input  logic               tick_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               rd_disabled_o,
  output logic               rd_illegal_o,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [NUM_CNT-1:0] wr_data_i
);
  logic [CNT_W-1:0]   cycle_q, time_q, instret_q;
  logic [NUM_CNT-1:0] mach_mask, super_mask;

  pcb_counters #(.CNT_W(CNT_W)) i_counters (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .retire_i  (retire_i),
    .tick_i    (tick_i),
    .cycle_o   (cycle_q),
    .time_o    (time_q),
    .instret_o (instret_q)
  );

  pcb_enables #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) i_enables (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .mach_mask_o  (mach_mask),
    .super_mask_o (super_mask)
  );

  pcb_gate #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) i_gate (
    .priv_i        (priv_i),
    .rd_addr_i     (rd_addr_i),
    .mach_mask_i   (mach_mask),
    .super_mask_i  (super_mask),
    .cycle_i       (cycle_q),
    .time_i        (time_q),
    .instret_i     (instret_q),
    .rd_data_o     (rd_data_o),
    .rd_disabled_o (rd_disabled_o),
    .rd_illegal_o  (rd_illegal_o)
  );
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_CNT = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        priv_i,
  input logic              retire_i,
  input logic              tick_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [CNT_W-1:0]  rd_data_o,
  input logic              rd_disabled_o,
  input logic              rd_illegal_o,
  input logic [CNT_W-1:0]  cycle_q,
  input logic [CNT_W-1:0]  time_q,
  input logic [CNT_W-1:0]  instret_q
);
  AST_CYCLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cycle_q == $past(cycle_q) + 1'b1); // R1

  AST_INSTRET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(instret_q)); // R2

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_q)); // R2

  AST_PERF_IS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= ADDR_W'(3) && rd_addr_i < ADDR_W'(NUM_CNT) && !rd_disabled_o)
      |-> rd_data_o == cycle_q); // R3

  AST_MACHINE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd3 && rd_addr_i < ADDR_W'(NUM_CNT)) |-> !rd_disabled_o); // R4

  AST_BLOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_disabled_o |-> rd_data_o == '0); // R6

  AST_RSVD_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd2 && rd_addr_i < ADDR_W'(NUM_CNT)) |-> rd_disabled_o); // R9

  AST_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i >= ADDR_W'(NUM_CNT) |-> (rd_illegal_o && !rd_disabled_o && rd_data_o == '0)); // R10
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
  .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .priv_i        (priv_i),
  .retire_i      (retire_i),
  .tick_i        (tick_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .rd_disabled_o (rd_disabled_o),
  .rd_illegal_o  (rd_illegal_o),
  .cycle_q       (cycle_q),
  .time_q        (time_q),
  .instret_q     (instret_q)
);

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv;
  logic        retire, tick;
  logic [5:0]  rd_addr;
  logic [63:0] rd_data;
  logic        rd_disabled, rd_illegal;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench mirror of counters and masks
  logic [63:0] m_cyc, m_tim, m_ins;
  logic [31:0] b_men, b_sen;

  always #2 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .retire_i(retire), .tick_i(tick),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_disabled_o(rd_disabled),
    .rd_illegal_o(rd_illegal), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc <= '0; m_tim <= '0; m_ins <= '0;
    end else begin
      m_cyc <= m_cyc + 1;
      if (tick)   m_tim <= m_tim + 1;
      if (retire) m_ins <= m_ins + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d priv=%0d actual=%h expected=%h", req, rd_addr, priv, act, exp);
    end
  endtask

  task automatic read_check(input int p, input int a);
    logic        allow;
    logic [63:0] val;
    string       dreq, freq;
    @(negedge clk);
    priv = p[1:0]; rd_addr = a[5:0];
    #1;
    if (a > 31) begin
      chk("R10 data", rd_data, 64'd0);
      chk("R10 flags", {62'd0, rd_illegal, rd_disabled}, 64'd2);
    end else begin
      case (p)
        3: begin allow = 1'b1;     freq = "R4"; end
        1: begin allow = b_men[a]; freq = "R5 supervisor"; end
        0: begin allow = b_sen[a]; freq = "R5 user"; end
        default: begin allow = 1'b0; freq = "R9"; end
      endcase
      val  = (a == 1) ? m_tim : (a == 2) ? m_ins : m_cyc;
      dreq = !allow ? "R6" : (a == 0) ? "R1" : (a < 3) ? "R2" : "R3";
      chk(dreq, rd_data, allow ? val : 64'd0);
      chk(freq, {62'd0, rd_illegal, rd_disabled}, {63'd0, !allow});
    end
  endtask

  task automatic sweep();
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 64; a++) begin
        retire = (a % 3 == 0);
        tick   = (a % 5 == 1);
        read_check(p, a);
      end
    retire = 0; tick = 0;
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[5:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 32) b_men = d;
    if (a == 33) b_sen = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; b_men = 32'h7; b_sen = 32'h7;
    #1;
    priv = 2'd3;
    for (int a = 0; a < 3; a++) begin
      rd_addr = a[5:0]; #0.1;
      chk("R1 R2 reset value", rd_data, 64'd0);
    end
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    rst_n = 0; priv = 0; retire = 0; tick = 0; rd_addr = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    b_men = 32'h7; b_sen = 32'h7;
    repeat (3) @(negedge clk);
    do_reset();
    // R8: default masks open indices 0..2 only
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 32; a++) begin
        @(negedge clk);
        priv = p[1:0]; rd_addr = a[5:0]; #1;
        chk("R8", {63'd0, rd_disabled}, {63'd0, a > 2});
      end
    // counters under an irregular pulse pattern
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      retire = (k % 3 != 1); tick = (k % 7 == 2);
    end
    retire = 0; tick = 0;
    sweep();
    write_reg(32, 32'hA5A5_3C0F); write_reg(33, 32'h5A5A_C3F0); sweep();
    write_reg(32, 32'hFFFF_FFFF); write_reg(33, 32'h0);         sweep();
    write_reg(32, 32'h0);         write_reg(33, 32'hFFFF_FFFF); sweep();
    // R7: writes to counter addresses and unused addresses are dropped
    write_reg(0, 32'hFFFF_FFFF); write_reg(1, 32'h1234_5678);
    write_reg(2, 32'hDEAD_BEEF); write_reg(17, 32'h55);
    write_reg(31, 32'h1);        write_reg(34, 32'h0);
    write_reg(63, 32'hFFFF_FFFF);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      priv = 2'd3; rd_addr = a[5:0]; #1;
      chk("R7 counter", rd_data, (a == 1) ? m_tim : (a == 2) ? m_ins : m_cyc);
    end
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      priv = 2'd1; rd_addr = a[5:0]; #1;
      chk("R7 machine mask", {63'd0, rd_disabled}, 64'd1);
      priv = 2'd0; #0.1;
      chk("R7 supervisor mask", {63'd0, rd_disabled}, 64'd0);
    end
    // reset mid-run: masks back to defaults
    do_reset();
    sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule